// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block receives 8-bit bytes from a clocked serial line. A host writes a small control word to choose the operating mode, start or abort reception, pick the serial clock source (an internal divider or an external clock pin) and pick the bit order. Each rising serial-clock edge captures one data bit into a shift register. After eight bits the byte moves into a read buffer, a receive-full flag is raised and a one-cycle interrupt pulse is sent.

When the block drives the serial clock itself, it parks that clock high after every byte until the host reads the buffer, so no data can be lost. When an external device drives the clock, the block cannot stall the sender. A byte that completes while the buffer is still unread sets an error flag, replaces the buffer contents and raises the interrupt again. Reception can end gracefully, where the current byte finishes first, or at once by an abort that clears every flag and the buffer.

Top module: `ssr_rx`

## Requirements
- R1: After reset, st_busy, st_shift, st_full, st_err and irq are 0, rx_byte is 0 and sck_out is 1.
- R2: Reception runs only while the stored mode field equals binary 01 and the stored start bit is 1. With any other mode value, st_busy stays 0 and sck_out stays 1.
- R3: Once reception is enabled, st_busy goes to 1 on the first serial-clock falling edge, and st_shift goes to 1 on the same edge.
- R4: One bit of si is taken on each serial-clock rising edge. With ctl_lsb_first = 0 the first bit received lands in rx_byte bit 7. With ctl_lsb_first = 1 it lands in bit 0.
- R5: On the eighth rising edge of a byte, the byte is copied to rx_byte, st_full is set, st_shift clears and irq is high for exactly one clk cycle.
- R6: A buf_rd pulse clears st_full, unless a byte completes in that same cycle.
- R7: In internal-clock mode (ctl_ext_clk = 0), each half period of sck_out lasts div_ratio+1 clk cycles. sck_out stays high while st_full is 1. After buf_rd, it falls within 2*(div_ratio+1)+1 cycles.
- R8: In external-clock mode (ctl_ext_clk = 1), sck_in and si pass through a two-flop synchronizer. A byte that completes while st_full is 1 and no buf_rd arrives in that cycle sets st_err, overwrites rx_byte and pulses irq. A byte that completes in the same cycle as buf_rd sets no error. A stat_rd pulse clears st_err.
- R9: Writing the start bit to 0 lets the byte in progress finish and load normally. st_busy then clears, and no new byte begins.
- R10: A control write with ctl_inhibit = 1 stops reception at once. It clears the start bit, st_busy, st_shift, st_full, st_err and rx_byte, and returns sck_out to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode field; binary 01 selects receive |
| ctl_start | input | 1 | Start/enable bit |
| ctl_inhibit | input | 1 | Abort request (acts during the write) |
| ctl_ext_clk | input | 1 | 1 = external sck_in, 0 = internal divider |
| ctl_lsb_first | input | 1 | Bit order select |
| div_ratio | input | DIV_W | Internal half-period length minus one |
| buf_rd | input | 1 | Host read of the receive buffer |
| stat_rd | input | 1 | Host read of the status flags |
| sck_in | input | 1 | External serial clock |
| si | input | 1 | Serial data in |
| sck_out | output | 1 | Internal serial clock, idle high |
| rx_byte | output | 8 | Receive buffer |
| st_busy | output | 1 | Operating flag |
| st_shift | output | 1 | Byte-in-progress flag |
| st_full | output | 1 | Receive-full flag |
| st_err | output | 1 | Overrun error flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
In external-clock mode, a host read of the buffer and the completion of the next byte can fall in the same clk cycle. The bench counts the synchronizer stages from its own sck_in edge and places buf_rd exactly in the cycle that loads the byte. It then expects st_full to stay 1, st_err to stay 0 and rx_byte to hold the new byte. The same scenario first provokes a real overrun by leaving the buffer unread, and judges the error flag, the overwritten buffer and the extra interrupt before a status read clears the error.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [1:0] MODE_RX = 2'b01;

  // Insert one received bit into the partial byte in the selected order.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] sr,
                                                 input logic bit_in,
                                                 input logic lsb_first);
    if (lsb_first) return {bit_in, sr[DATA_W-1:1]};
    else           return {sr[DATA_W-2:0], bit_in};
  endfunction

  // Last bit index of a byte.
  function automatic logic [CNT_W-1:0] last_bit();
    return CNT_W'(DATA_W - 1);
  endfunction
endpackage

// File: rtl/ssr_clkgen.sv
`timescale 1ns/1ps
module ssr_clkgen #(parameter int DIV_W = 8) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             term;

  assign term   = run_i && (cnt_q == div_i);
  assign fall_o = term && sck_q;
  assign rise_o = term && !sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (term) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2 / R7: a stopped generator parks the clock high
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> sck_o);
  // R7: the clock only toggles on a terminal count
  a_r7_toggle_on_term: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !term) |=> $stable(sck_o));
endmodule

// File: rtl/ssr_sync.sv
`timescale 1ns/1ps
module ssr_sync #(parameter int SYNC_N = 2) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic si_i,
  output logic rise_o,
  output logic fall_o,
  output logic si_o
);
  logic [SYNC_N:0]   sck_q;
  logic [SYNC_N-1:0] si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_N-1:0], sck_i};
      si_q  <= {si_q[SYNC_N-2:0], si_i};
    end
  end

  assign rise_o = sck_q[SYNC_N-1] && !sck_q[SYNC_N];
  assign fall_o = !sck_q[SYNC_N-1] && sck_q[SYNC_N];
  assign si_o   = si_q[SYNC_N-1];

  // R8: one synchronized edge gives exactly one event cycle
  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ssr_engine.sv
`timescale 1ns/1ps
module ssr_engine
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              go_i,
  input  logic              ext_i,
  input  logic              lsb_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic              buf_rd_i,
  input  logic              stat_rd_i,
  output logic              busy_o,
  output logic              shift_o,
  output logic              full_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sr_q, sr_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              begin_byte, overrun;

  assign sr_next    = shift_in(sr_q, din_i, lsb_i);
  assign begin_byte = fall_i && go_i && !shift_o;
  assign done_o     = rise_i && shift_o && (cnt_q == last_bit());
  assign overrun    = done_o && full_o && !buf_rd_i && ext_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; shift_o <= 1'b0; full_o <= 1'b0; err_o <= 1'b0;
      irq_o  <= 1'b0; cnt_q   <= '0;   sr_q   <= '0;   data_o <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0; shift_o <= 1'b0; full_o <= 1'b0; err_o <= 1'b0;
      irq_o  <= 1'b0; cnt_q   <= '0;   sr_q   <= '0;   data_o <= '0;
    end else begin
      if (begin_byte) begin
        busy_o  <= 1'b1;
        shift_o <= 1'b1;
        cnt_q   <= '0;
      end else if (!go_i && !shift_o) begin
        busy_o  <= 1'b0;
      end
      if (rise_i && shift_o) begin
        sr_q  <= sr_next;
        cnt_q <= cnt_q + 1'b1;
      end
      if (done_o) begin
        data_o  <= sr_next;
        shift_o <= 1'b0;
      end
      irq_o <= done_o;
      if (done_o)        full_o <= 1'b1;
      else if (buf_rd_i) full_o <= 1'b0;
      if (overrun)        err_o <= 1'b1;
      else if (stat_rd_i) err_o <= 1'b0;
    end
  end

  // R5: every interrupt comes with a loaded buffer
  a_r5_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> full_o);
  // R6: a read with no completing byte empties the buffer
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_i && !done_o && !abort_i) |=> !full_o);
  // R9: operation ends only between bytes or by abort
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(abort_i) || !$past(shift_o)));
  // R10: abort leaves everything cleared
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !shift_o && !full_o && !err_o && data_o == '0));
  // R8: errors arise only under an external clock
  a_r8_err_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(ext_i));
endmodule

// File: rtl/ssr_rx.sv
`timescale 1ns/1ps
module ssr_rx
  import ssr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_start,
  input  logic              ctl_inhibit,
  input  logic              ctl_ext_clk,
  input  logic              ctl_lsb_first,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              buf_rd,
  input  logic              stat_rd,
  input  logic              sck_in,
  input  logic              si,
  output logic              sck_out,
  output logic [DATA_W-1:0] rx_byte,
  output logic              st_busy,
  output logic              st_shift,
  output logic              st_full,
  output logic              st_err,
  output logic              irq
);
  logic [1:0] mode_q;
  logic       start_q, ext_q, lsb_q;
  logic       go, abort, run_int;
  logic       int_rise, int_fall, ext_rise, ext_fall, ext_din;
  logic       ser_rise, ser_fall, ser_din, byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00; start_q <= 1'b0; ext_q <= 1'b0; lsb_q <= 1'b0;
    end else if (ctl_we) begin
      mode_q  <= ctl_mode;
      start_q <= ctl_start && !ctl_inhibit;
      ext_q   <= ctl_ext_clk;
      lsb_q   <= ctl_lsb_first;
    end
  end

  assign abort   = ctl_we && ctl_inhibit;
  assign go      = start_q && (mode_q == MODE_RX);
  assign run_int = !ext_q && (go || st_shift) && !st_full && !abort;

  ssr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run_i(run_int), .div_i(div_ratio),
    .sck_o(sck_out), .fall_o(int_fall), .rise_o(int_rise)
  );

  ssr_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_in), .si_i(si),
    .rise_o(ext_rise), .fall_o(ext_fall), .si_o(ext_din)
  );

  assign ser_rise = ext_q ? ext_rise : int_rise;
  assign ser_fall = ext_q ? ext_fall : int_fall;
  assign ser_din  = ext_q ? ext_din  : si;

  ssr_engine u_engine (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .go_i(go), .ext_i(ext_q),
    .lsb_i(lsb_q), .rise_i(ser_rise), .fall_i(ser_fall), .din_i(ser_din),
    .buf_rd_i(buf_rd), .stat_rd_i(stat_rd), .busy_o(st_busy),
    .shift_o(st_shift), .full_o(st_full), .err_o(st_err), .irq_o(irq),
    .done_o(byte_done), .data_o(rx_byte)
  );

  // R7: auto-wait keeps the internal clock high while the buffer is full
  a_r7_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_q && st_full) |-> sck_out);
  // R3: operation starts only at a serial falling edge
  a_r3_busy_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_busy) |-> $past(ser_fall));
  // R5: a completed byte always raises the interrupt next cycle
  a_r5_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !abort) |=> irq);
endmodule

// File: tb/sim_ssr_rx.sv
`timescale 1ns/1ps
module sim_ssr_rx;
  localparam int DIV = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_mode = 2'b00;
  logic       ctl_start = 1'b0, ctl_inhibit = 1'b0, ctl_ext_clk = 1'b0, ctl_lsb_first = 1'b0;
  logic [7:0] div_ratio = 8'(DIV);
  logic       buf_rd = 1'b0, stat_rd = 1'b0, sck_in = 1'b1, si = 1'b0;
  logic       sck_out, st_busy, st_shift, st_full, st_err, irq;
  logic [7:0] rx_byte;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  ssr_rx u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
    .ctl_start(ctl_start), .ctl_inhibit(ctl_inhibit), .ctl_ext_clk(ctl_ext_clk),
    .ctl_lsb_first(ctl_lsb_first), .div_ratio(div_ratio), .buf_rd(buf_rd),
    .stat_rd(stat_rd), .sck_in(sck_in), .si(si), .sck_out(sck_out),
    .rx_byte(rx_byte), .st_busy(st_busy), .st_shift(st_shift),
    .st_full(st_full), .st_err(st_err), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt = irq_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [1:0] m, input logic st, input logic inh,
                     input logic ext, input logic lsb);
    @(negedge clk);
    ctl_mode = m; ctl_start = st; ctl_inhibit = inh; ctl_ext_clk = ext;
    ctl_lsb_first = lsb; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_inhibit = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  // Internal clock: present one bit after each falling edge of sck_out.
  task automatic int_byte(input logic [7:0] b, input logic lsb, input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge sck_out);
      #1 si = lsb ? b[i] : b[7-i];
      if (i == 0) begin
        chk({"R3 busy at first fall ", tag}, st_busy, 1);
        chk({"R3 shift at first fall ", tag}, st_shift, 1);
      end
    end
    @(posedge sck_out);
    repeat (2) @(negedge clk);
    chk({"R5 full after byte ", tag}, st_full, 1);
    chk({"R5 shift cleared ", tag}, st_shift, 0);
    chk({"R4 byte value ", tag}, rx_byte, b);
  endtask

  // External clock: low half then high half, data changes with the fall.
  task automatic ext_byte(input logic [7:0] b, input logic lsb, input bit rd_at_end);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_in = 1'b0; si = lsb ? b[i] : b[7-i];
      repeat (4) @(negedge clk);
      sck_in = 1'b1;
      if (i == 7 && rd_at_end) begin
        @(negedge clk); @(negedge clk);   // two sync stages passed
        buf_rd = 1'b1;                    // load cycle
        @(negedge clk); buf_rd = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", st_busy, 0);
    chk("R1 shift", st_shift, 0);
    chk("R1 full", st_full, 0);
    chk("R1 err", st_err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", rx_byte, 0);
    chk("R1 sck idle", sck_out, 1);
  endtask

  task automatic t_bad_mode();
    int lows = 0;
    ctl(2'b10, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sck_out) lows++;
    end
    chk("R2 no busy in wrong mode", st_busy, 0);
    chk("R2 clock idle in wrong mode", lows, 0);
    ctl(2'b00, 0, 0, 0, 0);
  endtask

  task automatic t_int_wait();
    int lows = 0, lat = 0, irq0;
    irq0 = irq_cnt;
    ctl(2'b01, 1, 0, 0, 0);
    int_byte(8'hA5, 0, "msb first");
    chk("R5 one irq", irq_cnt - irq0, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sck_out) lows++;
    end
    chk("R7 clock held high while full", lows, 0);
    chk("R7 still busy during wait", st_busy, 1);
    fork
      int_byte(8'h3C, 0, "after wait");
      begin
        @(negedge clk); buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0; lat = 1;
        chk("R6 read clears full", st_full, 0);
        while (sck_out && lat < 50) begin @(negedge clk); lat++; end
        chk("R7 resume latency", (lat <= 2*(DIV+1)+1), 1);
      end
    join
    // abort while waiting
    ctl(2'b01, 1, 1, 0, 0);
    chk("R10 full cleared", st_full, 0);
    chk("R10 data cleared", rx_byte, 0);
    chk("R10 busy cleared", st_busy, 0);
  endtask

  task automatic t_stop();
    int lows = 0;
    ctl(2'b01, 1, 0, 0, 1);
    fork
      int_byte(8'h96, 1, "lsb first");
      begin
        repeat (3) @(negedge sck_out);
        #3 ctl(2'b01, 0, 0, 0, 1);
      end
    join
    chk("R9 busy cleared after byte", st_busy, 0);
    pulse_rd();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sck_out) lows++;
    end
    chk("R9 no new byte", lows, 0);
    chk("R9 stays idle", st_busy, 0);
  endtask

  task automatic t_inhibit_mid();
    ctl(2'b01, 1, 0, 0, 0);
    si = 1'b1;
    repeat (4) @(negedge sck_out);
    #3 ctl(2'b01, 1, 1, 0, 0);
    chk("R10 shift cleared mid byte", st_shift, 0);
    chk("R10 busy cleared mid byte", st_busy, 0);
    chk("R10 sck high", sck_out, 1);
    repeat (10) @(negedge clk);
    chk("R10 start cleared", st_busy, 0);
  endtask

  task automatic t_ext();
    int irq0;
    ctl(2'b01, 1, 0, 1, 0);
    ext_byte(8'h5A, 0, 0);
    chk("R8 ext first byte", rx_byte, 8'h5A);
    chk("R8 ext full", st_full, 1);
    chk("R8 no error yet", st_err, 0);
    irq0 = irq_cnt;
    ext_byte(8'hC3, 0, 0);
    chk("R8 overrun error", st_err, 1);
    chk("R8 overwritten", rx_byte, 8'hC3);
    chk("R8 overrun irq", irq_cnt - irq0, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R8 status read clears error", st_err, 0);
    ext_byte(8'h81, 0, 1);
    chk("R8 read at completion no error", st_err, 0);
    chk("R8 read at completion full", st_full, 1);
    chk("R8 read at completion data", rx_byte, 8'h81);
    ctl(2'b01, 0, 1, 1, 0);
    chk("R10 ext abort err", st_err, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bad_mode();
    t_int_wait();
    t_stop();
    t_inhibit_mid();
    t_ext();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule